// File: doc/BRIEF.md
# USB IN Endpoint Buffer Arbiter

This block owns a single 64-byte transmit buffer for one USB IN endpoint. It sits between a register-side loader, such as firmware behind a register file, and an abstracted protocol engine that handles tokens and handshakes. The loader writes data bytes to explicit buffer addresses. It then writes a byte count, and that write is the only thing that arms the endpoint. When an IN token arrives, the block either answers with a NAK, if it is unarmed, or streams the armed number of bytes starting at address 0 and marks the end of the packet. The protocol engine then reports one of two results. An acknowledge frees the buffer: the buffer-available flag goes up, the endpoint disarms and the data toggle flips. A transfer error leaves everything armed, so the next token replays the same bytes.

The control is a four-state machine:
- `S_EMPTY`: unarmed. A token is answered with a NAK. A valid count write moves the machine to `S_ARMED`.
- `S_ARMED`: waiting for a token. A token rewinds the read index and moves the machine to `S_STREAM`.
- `S_STREAM`: one byte is sent per cycle. The cycle after the last byte (or at once, for a zero-length packet) carries the end marker, and the machine then moves to `S_AWAIT`.
- `S_AWAIT`: an acknowledge returns the machine to `S_EMPTY`. An error returns it to `S_ARMED`.

Top module: `usb_in_ep_arbiter`

## Requirements
- R1: An accepted byte count lies in the range 0 to 64. A count write above 64 is ignored: the endpoint stays unarmed and `bav_irq` is unchanged.
- R2: Writing buffer bytes never arms the endpoint. Only a count write does. An accepted count write sets `ep_armed` to 1 and clears `bav_irq` one cycle later.
- R3: An IN token while unarmed produces a one-cycle `nak` pulse in the following cycle. No `tx_valid` and no `tx_end` are produced.
- R4: After reset, `bav_irq`=1, `ep_armed`=0, `data_tog`=0, `nak`=0, `tx_valid`=0 and `tx_end`=0.
- R5: A token on an armed endpoint of length N is followed, from the next cycle on, by N consecutive `tx_valid` cycles carrying buffer bytes 0 to N-1. Then one `tx_end` cycle follows. Every response starts from address 0.
- R6: An acknowledge received after `tx_end` sets `bav_irq` to 1 and `ep_armed` to 0 in the next cycle.
- R7: An error received after `tx_end` keeps the endpoint armed. The next token resends the identical bytes.
- R8: `data_tog` inverts on each acknowledge and never changes on an error.
- R9: A count write while the endpoint is armed is ignored, and the armed length stays the same.
- R10: A count of 0 arms a zero-length packet. The token is followed by a single `tx_end` cycle with no `tx_valid`.
- R11: A write to the flag port with value 1 clears `bav_irq`. A write with value 0 leaves it unchanged. An acknowledge in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_wr | input | 1 | Buffer byte write strobe |
| ld_addr | input | 6 | Buffer byte address |
| ld_data | input | 8 | Buffer byte value |
| cnt_wr | input | 1 | Byte-count write strobe (arms the endpoint) |
| cnt_val | input | 7 | Byte count, 0 to 64 |
| flag_wr | input | 1 | Flag write strobe |
| flag_val | input | 1 | Flag write value (1 clears the flag) |
| tok_in | input | 1 | IN token event, one cycle |
| hs_ack | input | 1 | Host acknowledged the packet |
| hs_err | input | 1 | Transfer failed |
| nak | output | 1 | NAK answer pulse |
| tx_valid | output | 1 | Packet byte valid |
| tx_data | output | 8 | Packet byte |
| tx_end | output | 1 | End-of-packet marker |
| ep_armed | output | 1 | Endpoint holds an armed packet |
| bav_irq | output | 1 | Buffer-available interrupt flag |
| data_tog | output | 1 | Current data toggle (PID parity of the packet) |

## Verification
A stuck or wrongly entered state shows up within one or two cycles of the next token. Such a fault either gives a NAK where bytes were due, or bytes where a NAK was due, or it fails to give the `tx_end` marker after N data cycles. A read index that does not rewind corrupts the first byte of a retried packet at once. A wrong length register shows up as a byte-count mismatch at `tx_end`. Faults in the flag or the toggle become visible in the cycle after the acknowledge, the error or the clear write that should have moved them.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

    typedef enum logic [1:0] {
        S_EMPTY  = 2'd0,
        S_ARMED  = 2'd1,
        S_STREAM = 2'd2,
        S_AWAIT  = 2'd3
    } ep_state_e;

endpackage

// File: rtl/in_ep_store.sv
module in_ep_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DEPTH*DW-1:0] cells_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(g)))
                cell_q <= wr_data;
        end
        assign cells_flat[g*DW +: DW] = cell_q;
    end

    assign rd_data = cells_flat[rd_addr*DW +: DW];

endmodule

// File: rtl/in_ep_fsm.sv
module in_ep_fsm
    import in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_val,
    input  logic          tok_in,
    input  logic          hs_ack,
    input  logic          hs_err,
    output ep_state_e     state,
    output logic [AW-1:0] rd_idx,
    output logic          arm_evt,
    output logic          ack_evt,
    output logic          nak,
    output logic          tx_valid,
    output logic          tx_end
);

    localparam logic [CW-1:0] MAXLEN = CW'(DEPTH);

    ep_state_e     state_q, state_d;
    logic [CW-1:0] len_q;
    logic [CW-1:0] idx_q;
    logic          nak_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY:  if (cnt_wr && (cnt_val <= MAXLEN)) state_d = S_ARMED;
            S_ARMED:  if (tok_in)                       state_d = S_STREAM;
            S_STREAM: if (idx_q == len_q)               state_d = S_AWAIT;
            S_AWAIT: begin
                if (hs_ack)      state_d = S_EMPTY;
                else if (hs_err) state_d = S_ARMED;
            end
            default:             state_d = S_EMPTY;
        endcase
    end

    // Length, read index and NAK register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            idx_q <= '0;
            nak_q <= 1'b0;
        end else begin
            nak_q <= (state_q == S_EMPTY) && tok_in;
            if (arm_evt)
                len_q <= cnt_val;
            if ((state_q == S_ARMED) && tok_in)
                idx_q <= '0;
            else if ((state_q == S_STREAM) && (idx_q < len_q))
                idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        arm_evt  = (state_q == S_EMPTY) && cnt_wr && (cnt_val <= MAXLEN);
        ack_evt  = (state_q == S_AWAIT) && hs_ack;
        tx_valid = (state_q == S_STREAM) && (idx_q < len_q);
        tx_end   = (state_q == S_STREAM) && (idx_q == len_q);
        nak      = nak_q;
        rd_idx   = idx_q[AW-1:0];
        state    = state_q;
    end

    p_len_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_EMPTY) |-> (len_q <= MAXLEN));

    p_only_count_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_EMPTY) && !cnt_wr) |=> (state_q == S_EMPTY));

    p_nak_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_EMPTY) && tok_in) |=> (nak && !tx_valid && !tx_end));

    p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_ARMED) && tok_in) |=> (idx_q == '0));

    p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_AWAIT) && hs_err && !hs_ack) |=> (state_q == S_ARMED));

    p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_ARMED) && cnt_wr) |=> $stable(len_q));

endmodule

// File: rtl/in_ep_flags.sv
module in_ep_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_evt,
    input  logic ack_evt,
    input  logic flag_wr,
    input  logic flag_val,
    output logic bav,
    output logic tog
);

    logic bav_q;
    logic tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bav_q <= 1'b1;
            tog_q <= 1'b0;
        end else begin
            if (ack_evt)
                bav_q <= 1'b1;
            else if (arm_evt || (flag_wr && flag_val))
                bav_q <= 1'b0;
            if (ack_evt)
                tog_q <= ~tog_q;
        end
    end

    assign bav = bav_q;
    assign tog = tog_q;

    p_bav_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |=> bav_q);

    p_toggle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_evt |=> $stable(tog_q));

    p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |=> (tog_q != $past(tog_q)));

    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bav_q && flag_wr && !flag_val && !arm_evt) |=> bav_q);

endmodule

// File: rtl/usb_in_ep_arbiter.sv
module usb_in_ep_arbiter
    import in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_wr,
    input  logic [$clog2(DEPTH)-1:0]   ld_addr,
    input  logic [DW-1:0]              ld_data,
    input  logic                       cnt_wr,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_val,
    input  logic                       flag_wr,
    input  logic                       flag_val,
    input  logic                       tok_in,
    input  logic                       hs_ack,
    input  logic                       hs_err,
    output logic                       nak,
    output logic                       tx_valid,
    output logic [DW-1:0]              tx_data,
    output logic                       tx_end,
    output logic                       ep_armed,
    output logic                       bav_irq,
    output logic                       data_tog
);

    localparam int AW = $clog2(DEPTH);

    ep_state_e     state;
    logic [AW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic          arm_evt;
    logic          ack_evt;

    in_ep_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (ld_wr),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_idx),
        .rd_data (rd_data)
    );

    in_ep_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_wr   (cnt_wr),
        .cnt_val  (cnt_val),
        .tok_in   (tok_in),
        .hs_ack   (hs_ack),
        .hs_err   (hs_err),
        .state    (state),
        .rd_idx   (rd_idx),
        .arm_evt  (arm_evt),
        .ack_evt  (ack_evt),
        .nak      (nak),
        .tx_valid (tx_valid),
        .tx_end   (tx_end)
    );

    in_ep_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_evt  (arm_evt),
        .ack_evt  (ack_evt),
        .flag_wr  (flag_wr),
        .flag_val (flag_val),
        .bav      (bav_irq),
        .tog      (data_tog)
    );

    assign ep_armed = (state != S_EMPTY);
    assign tx_data  = tx_valid ? rd_data : '0;

    p_stream_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, tx_end, nak}));

endmodule

// File: tb/usb_in_ep_arbiter_tb.sv
`timescale 1ns/1ps
module usb_in_ep_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_wr, cnt_wr, flag_wr, flag_val, tok_in, hs_ack, hs_err;
    logic [5:0] ld_addr;
    logic [7:0] ld_data;
    logic [6:0] cnt_val;
    logic       nak, tx_valid, tx_end, ep_armed, bav_irq, data_tog;
    logic [7:0] tx_data;

    int total = 0;
    int bad   = 0;
    logic       exp_tog = 1'b0;
    logic [7:0] shadow [64];

    always #10 clk = ~clk;

    usb_in_ep_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .ld_wr(ld_wr), .ld_addr(ld_addr), .ld_data(ld_data),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .flag_wr(flag_wr), .flag_val(flag_val),
        .tok_in(tok_in), .hs_ack(hs_ack), .hs_err(hs_err), .nak(nak),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_end(tx_end),
        .ep_armed(ep_armed), .bav_irq(bav_irq), .data_tog(data_tog)
    );

    // {length[6:0], seed[7:0]}
    localparam logic [14:0] VECS [6] = '{
        {7'd1,  8'h10}, {7'd5,  8'hA0}, {7'd64, 8'h03},
        {7'd2,  8'hF0}, {7'd63, 8'h55}, {7'd17, 8'h7E}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            ld_wr = 1'b1; ld_addr = 6'(i); ld_data = seed + 8'(i * 3);
            shadow[i] = seed + 8'(i * 3);
            cyc();
        end
        ld_wr = 1'b0;
    endtask

    task automatic write_cnt(input int v);
        cnt_wr = 1'b1; cnt_val = 7'(v);
        cyc();
        cnt_wr = 1'b0;
    endtask

    task automatic token();
        tok_in = 1'b1;
        cyc();
        tok_in = 1'b0;
    endtask

    // Called right after token(); checks the byte stream and waits for tx_end.
    task automatic collect(input string tag, input int exp_len);
        int n = 0;
        for (int g = 0; g < 100; g++) begin
            if (tx_valid) begin
                if (tx_data !== shadow[n[5:0]]) chk({tag, " data"}, tx_data, shadow[n[5:0]]);
                n++;
            end
            if (tx_end) break;
            cyc();
        end
        chk({tag, " length"}, n, exp_len);
        chk({tag, " end seen"}, tx_end, 1'b1);
        cyc();
    endtask

    task automatic handshake(input logic ack);
        hs_ack = ack; hs_err = ~ack;
        cyc();
        hs_ack = 1'b0; hs_err = 1'b0;
        if (ack) exp_tog = ~exp_tog;
    endtask

    initial begin
        #4000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_wr = 0; ld_addr = 0; ld_data = 0; cnt_wr = 0; cnt_val = 0;
        flag_wr = 0; flag_val = 0; tok_in = 0; hs_ack = 0; hs_err = 0;
        @(negedge clk); cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // R4 reset state
        chk("R4 bav", bav_irq, 1); chk("R4 armed", ep_armed, 0);
        chk("R4 tog", data_tog, 0); chk("R4 nak", nak, 0);
        chk("R4 valid/end", {tx_valid, tx_end}, 0);

        // R3 token while unarmed
        token();
        chk("R3 nak", nak, 1); chk("R3 no data", {tx_valid, tx_end}, 0);
        cyc();
        chk("R3 nak one cycle", nak, 0);

        // R2 loading alone does not arm
        load(8, 8'h21);
        chk("R2 not armed", ep_armed, 0);
        token();
        chk("R2 nak after load", nak, 1);

        // R1 count above 64 ignored
        write_cnt(65);
        chk("R1 armed", ep_armed, 0); chk("R1 bav", bav_irq, 1);
        token();
        chk("R1 still nak", nak, 1);

        // R11 clear with 0 then 1
        flag_wr = 1; flag_val = 0; cyc(); flag_wr = 0;
        chk("R11 zero write", bav_irq, 1);
        flag_wr = 1; flag_val = 1; cyc(); flag_wr = 0;
        chk("R11 one write", bav_irq, 0);

        // Vector table: R2 arm, R5 stream, R6 ack, R8 toggle
        foreach (VECS[k]) begin
            load(int'(VECS[k][14:8]), VECS[k][7:0]);
            write_cnt(int'(VECS[k][14:8]));
            chk("R2 armed", ep_armed, 1); chk("R2 bav cleared", bav_irq, 0);
            token();
            collect("R5 vec", int'(VECS[k][14:8]));
            handshake(1'b1);
            chk("R6 bav", bav_irq, 1); chk("R6 disarmed", ep_armed, 0);
            chk("R8 toggle", data_tog, exp_tog);
        end

        // R7 retry after error
        load(4, 8'hC4);
        write_cnt(4);
        token();
        collect("R7 first", 4);
        handshake(1'b0);
        chk("R7 armed", ep_armed, 1); chk("R7 bav", bav_irq, 0);
        chk("R8 toggle unchanged on error", data_tog, exp_tog);
        token();
        collect("R7 replay", 4);
        handshake(1'b1);
        chk("R8 toggle after ack", data_tog, exp_tog);

        // R9 count write while armed ignored
        load(3, 8'h90);
        write_cnt(3);
        write_cnt(10);
        token();
        collect("R9 length kept", 3);
        handshake(1'b1);

        // R10 zero-length packet
        write_cnt(0);
        chk("R10 armed", ep_armed, 1);
        token();
        chk("R10 end only", {tx_valid, tx_end}, 2'b01);
        collect("R10 zlp", 0);
        handshake(1'b1);
        chk("R10 bav", bav_irq, 1);

        // R11 ack beats a simultaneous clear
        write_cnt(1);
        token();
        collect("R11 pkt", 1);
        hs_ack = 1; flag_wr = 1; flag_val = 1;
        cyc();
        hs_ack = 0; flag_wr = 0; flag_val = 0; exp_tog = ~exp_tog;
        chk("R11 ack wins", bav_irq, 1);
        chk("R8 toggle final", data_tog, exp_tog);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule